// File: doc/BRIEF.md
# Pipelined Givens Rotation Cell

This block applies one Givens rotation to a pair of matrix rows that arrive as a stream of element pairs, one pair per clock. Each pair holds the element of the upper row and the element of the lower row from the same column. The first pair of a row is marked as leading. The block turns that pair into its magnitude and a zero, and it records the rotation as a sequence of direction bits, one for each iteration. Every later pair of the same two rows is then rotated by exactly that angle, by replaying the recorded bits. The block computes no numeric angle and has no multiplier.

The datapath has three parts, each a chain of shift-add stages. First, a linear-mode stage pre-scales both elements by a power of the inverse rotation gain chosen from the row index. Second, a circular stage vectors the leading pair and rotates the trailing pairs. Third, a second linear-mode stage post-scales by another power of the gain, so the net gain comes out as one. A new pair can enter on every cycle. A new leading pair can follow the last trailing pair of the previous row with no gap. Scheduling the rotations across a whole matrix is left to the logic around the block.

Top module: `givens_cell`

## Requirements
- R1: The synchronous active-low reset clears every in-flight valid flag. While reset is asserted `out_valid` is low, and it stays low until the first accepted pair has crossed the pipeline.
- R2: A pair accepted with `in_valid` high leaves the block exactly LAT = 2·LIN_STG + ITERS + 1 cycles later (57 with the default parameters). At that point `out_valid` is high, and `out_first` and `out_row` carry the values the pair entered with.
- R3: For a leading pair (`in_first` = 1) with upper element a and lower element b, `out_a` is √(a²+b²) within 4 LSB and is never negative, and `out_b` is within 4 LSB of zero.
- R4: For a trailing pair (`in_first` = 0) with elements (a, b), the outputs are a·c + b·s and b·c − a·s, each within 4 LSB. Here c = a0/r0 and s = b0/r0 come from the most recent leading pair (a0, b0), and r0 is its magnitude.
- R5: R3 and R4 hold in every quadrant, including a leading pair whose upper element is negative. Such a pair is first folded by a half-turn that the trailing pairs also receive.
- R6: The row index `in_row` (0 to ROWS−1) selects a pre-scale of K^−(ROWS−row) and a post-scale of K^(ROWS−1−row), where K ≈ 1.64676 is the circular gain. Every row value therefore gives the same outputs within 4 LSB.
- R7: A leading pair may enter in the cycle right after a trailing pair of the previous row. The earlier pairs keep the old angle and the later pairs take the new one.
- R8: Cycles with `in_valid` low between a leading pair and its trailing pairs leave the held angle unchanged.
- R9: A cycle with `in_valid` low produces a cycle with `out_valid` low LAT cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An element pair is present this cycle |
| in_first | input | 1 | The pair is the leading pair of a row: vector it and record its angle |
| in_row | input | $clog2(ROWS) | Row index that selects the gain-correction powers |
| in_a | input | W | Upper-row element, signed two's complement |
| in_b | input | W | Lower-row element, signed two's complement |
| out_valid | output | 1 | A rotated pair is present this cycle |
| out_first | output | 1 | Leading flag carried with the pair |
| out_row | output | $clog2(ROWS) | Row index carried with the pair |
| out_a | output | W | Rotated upper element (the magnitude for a leading pair) |
| out_b | output | W | Rotated lower element (near zero for a leading pair) |

## Verification
Two functions can meet in the same cycle. When rows arrive back to back, a new leading pair overwrites the direction bit of a circular stage in the same cycle that the previous row's last trailing pair, one stage further on, still rotates with its own bit. The bench provokes this by sending rows with no idle cycle between them, including rows of a single pair. It judges the result by comparing every output pair of both rows against a floating-point rotation that uses each row's own leading angle. Randomised rows with random gaps and random row indices, plus rows separated by idle cycles, cover the same boundary at other spacings.

// File: rtl/gv_pkg.sv
// Shared constants for the Givens rotation cell.
// Assumes the circular iteration count is large enough that the gain equals K
// to within the fixed-point precision used here (Q30).
package gv_pkg;
    localparam int    ZW     = 36;                 // width of the linear-mode angle accumulator
    localparam int    ZF     = 30;                 // fraction bits of gain constants
    localparam longint K_Q    = 64'sd1768195367;   // circular gain K in Q30
    localparam longint KINV_Q = 64'sd652032875;    // 1/K in Q30

    // K raised to an integer power, in Q30, by repeated fixed-point products
    function automatic longint k_power(input int e);
        longint acc;
        acc = longint'(1) <<< ZF;
        for (int i = 0; i < ((e < 0) ? -e : e); i++)
            acc = (acc * ((e < 0) ? KINV_Q : K_Q)) >>> ZF;
        return acc;
    endfunction
endpackage

// File: rtl/gv_lin_scale.sv
// Linear-mode CORDIC multiplier: multiplies x and y by the constant carried in z.
// One shift-add step per stage; the shift of stage g is SH0+g (negative = left).
// Assumes |z| stays below the convergence bound (about 2^(1-SH0)).
module gv_lin_scale
    import gv_pkg::*;
#(
    parameter int DW  = 28,
    parameter int TW  = 3,
    parameter int STG = 20,
    parameter int SH0 = -2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [TW-1:0]        in_tag,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    input  logic signed [ZW-1:0] in_z,
    output logic                 out_vld,
    output logic [TW-1:0]        out_tag,
    output logic signed [DW-1:0] out_x,
    output logic signed [DW-1:0] out_y
);
    logic                 vld_q  [STG];
    logic [TW-1:0]        tag_q  [STG];
    logic signed [DW-1:0] ax_q   [STG];
    logic signed [DW-1:0] ay_q   [STG];
    logic signed [DW-1:0] sx_q   [STG-1];
    logic signed [DW-1:0] sy_q   [STG-1];
    logic signed [ZW-1:0] z_q    [STG-1];

    logic                 src_v  [STG];
    logic [TW-1:0]        src_t  [STG];
    logic signed [DW-1:0] src_x  [STG];
    logic signed [DW-1:0] src_y  [STG];
    logic signed [DW-1:0] src_ax [STG];
    logic signed [DW-1:0] src_ay [STG];
    logic signed [ZW-1:0] src_z  [STG];
    logic signed [DW-1:0] tx     [STG];
    logic signed [DW-1:0] ty     [STG];
    logic signed [ZW-1:0] zstep  [STG];

    // route each stage's operands from the input or from the previous stage
    always_comb begin
        src_v[0]  = in_vld;
        src_t[0]  = in_tag;
        src_x[0]  = in_x;
        src_y[0]  = in_y;
        src_z[0]  = in_z;
        src_ax[0] = '0;
        src_ay[0] = '0;
        for (int g = 1; g < STG; g++) begin
            src_v[g]  = vld_q[g-1];
            src_t[g]  = tag_q[g-1];
            src_x[g]  = sx_q[g-1];
            src_y[g]  = sy_q[g-1];
            src_z[g]  = z_q[g-1];
            src_ax[g] = ax_q[g-1];
            src_ay[g] = ay_q[g-1];
        end
    end

    // fixed shifts and angle steps, one set per stage
    for (genvar g = 0; g < STG; g++) begin : g_shift
        localparam int S  = SH0 + g;
        localparam int LS = (S < 0) ? -S : 0;
        localparam int RS = (S < 0) ? 0 : S;
        localparam logic signed [ZW-1:0] STEP = ZW'(longint'(1) <<< (ZF - S));
        assign tx[g]    = (src_x[g] <<< LS) >>> RS;
        assign ty[g]    = (src_y[g] <<< LS) >>> RS;
        assign zstep[g] = STEP;
    end

    // advance every stage by one signed shift-add step
    always_ff @(posedge clk) begin
        for (int g = 0; g < STG; g++) begin
            if (!rst_n) vld_q[g] <= 1'b0;
            else        vld_q[g] <= src_v[g];
            tag_q[g] <= src_t[g];
            if (!src_z[g][ZW-1]) begin
                ax_q[g] <= src_ax[g] + tx[g];
                ay_q[g] <= src_ay[g] + ty[g];
            end else begin
                ax_q[g] <= src_ax[g] - tx[g];
                ay_q[g] <= src_ay[g] - ty[g];
            end
        end
    end

    // carry the multiplicands and the residual constant to the next stage
    always_ff @(posedge clk) begin
        for (int g = 0; g < STG-1; g++) begin
            sx_q[g] <= src_x[g];
            sy_q[g] <= src_y[g];
            z_q[g]  <= src_z[g][ZW-1] ? src_z[g] + zstep[g] : src_z[g] - zstep[g];
        end
    end

    assign out_vld = vld_q[STG-1];
    assign out_tag = tag_q[STG-1];
    assign out_x   = ax_q[STG-1];
    assign out_y   = ay_q[STG-1];
endmodule

// File: rtl/gv_circ_core.sv
// Circular CORDIC with per-stage direction memory.
// Stage 0 folds the left half-plane by a half-turn. Stages 1..ITERS vector a
// leading pair (tag bit 0 set) and store each direction bit; other pairs
// replay the stored bits, so they receive the same rotation.
// Assumes the leading pair of a row enters before its trailing pairs.
module gv_circ_core #(
    parameter int DW    = 28,
    parameter int TW    = 3,
    parameter int ITERS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [TW-1:0]        in_tag,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    output logic                 out_vld,
    output logic [TW-1:0]        out_tag,
    output logic signed [DW-1:0] out_x,
    output logic signed [DW-1:0] out_y
);
    logic                 vld_q [ITERS+1];
    logic [TW-1:0]        tag_q [ITERS+1];
    logic signed [DW-1:0] x_q   [ITERS+1];
    logic signed [DW-1:0] y_q   [ITERS+1];
    logic [ITERS-1:0]     dir_q;
    logic                 flip_q;
    logic                 lead_in, flip_now;
    logic [ITERS-1:0]     lead, dnow;
    logic signed [DW-1:0] shx [ITERS];
    logic signed [DW-1:0] shy [ITERS];

    // half-turn decision: taken from a leading pair, replayed for the rest
    assign lead_in  = in_vld & in_tag[0];
    assign flip_now = lead_in ? in_x[DW-1] : flip_q;

    // per-iteration shifted operands and chosen direction
    for (genvar g = 0; g < ITERS; g++) begin : g_rot
        assign shx[g]  = x_q[g] >>> g;
        assign shy[g]  = y_q[g] >>> g;
        assign lead[g] = vld_q[g] & tag_q[g][0];
        assign dnow[g] = lead[g] ? ~y_q[g][DW-1] : dir_q[g];
    end

    // fold stage plus ITERS micro-rotation stages, recording directions on leads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            flip_q   <= 1'b0;
        end else begin
            vld_q[0] <= in_vld;
            if (lead_in) flip_q <= in_x[DW-1];
        end
        tag_q[0] <= in_tag;
        x_q[0]   <= flip_now ? -in_x : in_x;
        y_q[0]   <= flip_now ? -in_y : in_y;
        for (int g = 0; g < ITERS; g++) begin
            if (!rst_n) begin
                vld_q[g+1] <= 1'b0;
                dir_q[g]   <= 1'b0;
            end else begin
                vld_q[g+1] <= vld_q[g];
                if (lead[g]) dir_q[g] <= dnow[g];
            end
            tag_q[g+1] <= tag_q[g];
            if (dnow[g]) begin
                x_q[g+1] <= x_q[g] + shy[g];
                y_q[g+1] <= y_q[g] - shx[g];
            end else begin
                x_q[g+1] <= x_q[g] - shy[g];
                y_q[g+1] <= y_q[g] + shx[g];
            end
        end
    end

    assign out_vld = vld_q[ITERS];
    assign out_tag = tag_q[ITERS];
    assign out_x   = x_q[ITERS];
    assign out_y   = y_q[ITERS];
endmodule

// File: rtl/givens_cell.sv
// Givens rotation cell: pre-scale, circular vectoring/rotation, post-scale.
// Inputs are widened by FG guard fraction bits. The gain powers are computed
// at elaboration into a table indexed by row. Assumes ROWS > 1 and inputs
// small enough that the rotated pair fits in W bits.
module givens_cell
    import gv_pkg::*;
#(
    parameter int W       = 16,
    parameter int ROWS    = 4,
    parameter int ITERS   = 16,
    parameter int LIN_STG = 20,
    parameter int FG      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_first,
    input  logic [$clog2(ROWS)-1:0]     in_row,
    input  logic signed [W-1:0]         in_a,
    input  logic signed [W-1:0]         in_b,
    output logic                        out_valid,
    output logic                        out_first,
    output logic [$clog2(ROWS)-1:0]     out_row,
    output logic signed [W-1:0]         out_a,
    output logic signed [W-1:0]         out_b
);
    localparam int RW  = $clog2(ROWS);
    localparam int TW  = RW + 1;
    localparam int IW  = W + FG + 4;
    localparam int LAT = 2 * LIN_STG + ITERS + 1;

    logic signed [ZW-1:0] pre_tab  [ROWS];
    logic signed [ZW-1:0] post_tab [ROWS];

    // gain powers per row: K^-(ROWS-row) before, K^(ROWS-1-row) after
    for (genvar r = 0; r < ROWS; r++) begin : g_tab
        localparam logic signed [ZW-1:0] PRE_C  = ZW'(k_power(r - ROWS));
        localparam logic signed [ZW-1:0] POST_C = ZW'(k_power(ROWS - 1 - r));
        assign pre_tab[r]  = PRE_C;
        assign post_tab[r] = POST_C;
    end

    logic signed [IW-1:0] ext_a, ext_b;
    logic                 pr_vld, cr_vld, po_vld;
    logic [TW-1:0]        pr_tag, cr_tag, po_tag;
    logic signed [IW-1:0] pr_x, pr_y, cr_x, cr_y, po_x, po_y;

    assign ext_a = IW'(in_a) <<< FG;
    assign ext_b = IW'(in_b) <<< FG;

    gv_lin_scale #(.DW(IW), .TW(TW), .STG(LIN_STG), .SH0(-2)) pre_i (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_valid), .in_tag({in_row, in_first}),
        .in_x(ext_a), .in_y(ext_b), .in_z(pre_tab[in_row]),
        .out_vld(pr_vld), .out_tag(pr_tag), .out_x(pr_x), .out_y(pr_y)
    );

    gv_circ_core #(.DW(IW), .TW(TW), .ITERS(ITERS)) circ_i (
        .clk(clk), .rst_n(rst_n),
        .in_vld(pr_vld), .in_tag(pr_tag), .in_x(pr_x), .in_y(pr_y),
        .out_vld(cr_vld), .out_tag(cr_tag), .out_x(cr_x), .out_y(cr_y)
    );

    gv_lin_scale #(.DW(IW), .TW(TW), .STG(LIN_STG), .SH0(-2)) post_i (
        .clk(clk), .rst_n(rst_n),
        .in_vld(cr_vld), .in_tag(cr_tag),
        .in_x(cr_x), .in_y(cr_y), .in_z(post_tab[cr_tag[TW-1:1]]),
        .out_vld(po_vld), .out_tag(po_tag), .out_x(po_x), .out_y(po_y)
    );

    assign out_valid = po_vld;
    assign out_first = po_tag[0];
    assign out_row   = po_tag[TW-1:1];
    assign out_a     = W'(po_x >>> FG);
    assign out_b     = W'(po_y >>> FG);
endmodule

// File: rtl/givens_cell_chk.sv
// Port-level properties of givens_cell, attached by bind.
// Counts cycles since reset and pairs in flight to bound latency without deep $past.
module givens_cell_chk #(
    parameter int W   = 16,
    parameter int LAT = 57,
    parameter int TOL = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                out_valid,
    input logic                out_first,
    input logic signed [W-1:0] out_a,
    input logic signed [W-1:0] out_b
);
    int since_q;
    int inflight_q;

    // cycles since reset, saturating at the pipeline depth
    always_ff @(posedge clk) begin
        if (!rst_n)             since_q <= 0;
        else if (since_q < LAT) since_q <= since_q + 1;
    end

    // pairs accepted but not yet delivered
    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= 0;
        else        inflight_q <= inflight_q + (in_valid ? 1 : 0) - (out_valid ? 1 : 0);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R2
    latency_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> since_q >= LAT);

    // R2
    inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight_q > 0);

    // R3
    lead_mag_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_first) |-> out_a >= 0);

    // R3
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_first) |-> (out_b <= TOL && out_b >= -TOL));
endmodule

bind givens_cell givens_cell_chk #(.W(W), .LAT(LAT), .TOL(4)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_first(out_first), .out_a(out_a), .out_b(out_b)
);

// File: tb/givens_cell_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural model holds one expected entry per cycle in a queue
// and compares it with the outputs LAT cycles later.
module givens_cell_tb_top;
    localparam int W    = 16;
    localparam int ROWS = 4;
    localparam int RW   = 2;
    localparam int LAT  = 57;
    localparam real TOL = 4.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_first = 1'b0;
    logic [RW-1:0] in_row = '0;
    logic signed [W-1:0] in_a = '0, in_b = '0;
    logic out_valid, out_first;
    logic [RW-1:0] out_row;
    logic signed [W-1:0] out_a, out_b;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct {
        bit    v;
        bit    f;
        int    row;
        real   ea;
        real   eb;
        string rq;
    } exp_t;

    exp_t q[$];
    real cur_c = 1.0;
    real cur_s = 0.0;

    always #2 clk = ~clk;

    givens_cell dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_row(in_row), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_first(out_first), .out_row(out_row), .out_a(out_a), .out_b(out_b)
    );

    task automatic fail_msg(input string rq, input string what, input real act, input real expv);
        n_err++;
        $display("FAIL %s %s: actual %0.3f expected %0.3f", rq, what, act, expv);
    endtask

    task automatic check_out(input exp_t e);
        real da, db;
        n_chk++;
        if (out_valid !== e.v) begin
            fail_msg(e.v ? "R2" : "R9", "out_valid", real'(out_valid), real'(e.v));
            return;
        end
        if (!e.v) return;
        n_chk++;
        if (out_first !== e.f || int'(out_row) != e.row)
            fail_msg("R2", "first/row tag", real'(int'(out_row) * 2 + int'(out_first)),
                     real'(e.row * 2 + int'(e.f)));
        da = real'(int'(out_a)) - e.ea;
        db = real'(int'(out_b)) - e.eb;
        n_chk++;
        if (da > TOL || da < -TOL) fail_msg(e.rq, "out_a", real'(int'(out_a)), e.ea);
        n_chk++;
        if (db > TOL || db < -TOL) fail_msg(e.rq, "out_b", real'(int'(out_b)), e.eb);
    endtask

    // one clock of stimulus: compare the entry due now, then drive and record a new one
    task automatic step(input bit v, input bit f, input int row, input int a, input int b,
                        input string rq);
        exp_t e;
        real ra, rb, r;
        @(negedge clk);
        if (q.size() == LAT) check_out(q.pop_front());
        else begin
            n_chk++;
            if (out_valid !== 1'b0) fail_msg("R1", "out_valid while pipeline empty",
                                             real'(out_valid), 0.0);
        end
        in_valid = v; in_first = f; in_row = RW'(row);
        in_a = W'(a); in_b = W'(b);
        ra = real'(a); rb = real'(b);
        e.v = v; e.f = f; e.row = row; e.rq = rq; e.ea = 0.0; e.eb = 0.0;
        if (v) begin
            if (f) begin
                r = $sqrt(ra * ra + rb * rb);
                cur_c = ra / r;
                cur_s = rb / r;
            end
            e.ea = cur_c * ra + cur_s * rb;
            e.eb = cur_c * rb - cur_s * ra;
        end
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 0, "R9");
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0) fail_msg("R1", "out_valid in reset", real'(out_valid), 0.0);
        rst_n = 1'b1;

        // R3, R4: one row, first quadrant leader, trailers of mixed signs
        step(1, 1, 3, 3000, 4000, "R3");
        step(1, 0, 3, 1000, -2000, "R4");
        step(1, 0, 3, -1500, 2500, "R4");
        step(1, 0, 3, 0, 3000, "R4");
        idle(3);

        // R5: leaders in the left half-plane and on the axes
        step(1, 1, 1, -2500, 1200, "R5");
        step(1, 0, 1, 2000, 2000, "R5");
        step(1, 0, 1, -3000, -500, "R5");
        step(1, 1, 2, -2000, -3000, "R5");
        step(1, 0, 2, 1500, -2500, "R5");
        step(1, 1, 0, 0, 3500, "R3");
        step(1, 0, 0, 2500, 100, "R4");
        step(1, 1, 0, 2800, 0, "R3");
        step(1, 0, 0, -1000, 1700, "R4");
        step(1, 1, 2, 0, -2600, "R5");
        step(1, 0, 2, 900, 900, "R5");
        idle(2);

        // R6: same row content under every row index
        for (int r = 0; r < ROWS; r++) begin
            step(1, 1, r, 1234, -3210, "R6");
            step(1, 0, r, 2222, 1111, "R6");
            step(1, 0, r, -3999, 3999, "R6");
        end

        // R7: rows back to back, including single-pair rows
        step(1, 1, 1, 3900, -200, "R7");
        step(1, 0, 1, 100, 3800, "R7");
        step(1, 1, 2, -300, 3700, "R7");
        step(1, 1, 3, -3600, -1800, "R7");
        step(1, 0, 3, 2500, -2500, "R7");
        step(1, 1, 0, 1000, 1000, "R7");
        step(1, 0, 0, -2000, 3000, "R7");
        step(1, 0, 0, 3000, -2000, "R7");

        // R8: idle cycles between a leader and its trailers
        step(1, 1, 2, -1800, 2900, "R8");
        idle(5);
        step(1, 0, 2, 2700, 1300, "R8");
        idle(1);
        step(1, 0, 2, -600, -3300, "R8");
        idle(LAT + 3);

        // R4, R7, R9: random rows, random gaps, random row index
        for (int k = 0; k < 60; k++) begin
            int a0, b0, nt, rw;
            a0 = int'($urandom_range(8000)) - 4000;
            b0 = int'($urandom_range(8000)) - 4000;
            if (a0 * a0 + b0 * b0 < 1000000) a0 = (a0 < 0) ? -1500 : 1500;
            rw = int'($urandom_range(ROWS - 1));
            nt = int'($urandom_range(3));
            step(1, 1, rw, a0, b0, "R3");
            for (int t = 0; t < nt; t++) begin
                if ($urandom_range(3) == 0) idle(1);
                step(1, 0, rw, int'($urandom_range(8000)) - 4000,
                     int'($urandom_range(8000)) - 4000, "R4");
            end
            if ($urandom_range(1) == 0) idle(int'($urandom_range(2)));
        end

        // drain
        idle(LAT + 2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule